// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block learns the bit rate of a serial host from a single calibration character. Once armed, it watches the receive line. The host sends an all-zero byte, so the line stays low for the start bit and the eight data bits. The block times that nine-bit low span with a counter that advances once every four system clocks. It then turns the count into a reload value with a rounding subtract-and-divide loop. The divisor is not fixed in configuration.

When the division finishes, the block pulses `done_o`, presents the reload value and starts a baud generator. The generator emits a one-cycle tick at sixteen times the learned bit rate, which a UART receiver and transmitter can use for oversampling. A span that overflows the counter, or that is too short to give a positive reload, raises an error flag instead. The error flag stays set until the block is armed again.

Top module: `autobaud_detect`

## Requirements
- R1: After reset, `reload_o` is 0 and `done_o`, `err_o` and `tick_o` are all 0.
- R2: The receive line passes through a two-stage synchronizer. Timing starts on the first high-to-low transition seen after `arm_i`; a line that is already low when armed must go high first. Timing stops on the next low-to-high transition. With L the number of clocks the line is low, the count is floor(L/4).
- R3: When the count is at least 72, the block computes reload = floor((count − 36) / 72) with a sequential loop. It then pulses `done_o` high for exactly one cycle, and `reload_o` already holds the new value in that cycle.
- R4: If the counter reaches its all-ones value (2^CNT_W − 1) while the line is still low, `err_o` goes to 1 at once and no `done_o` follows.
- R5: A count below 72 at the rising edge sets `err_o` to 1 and produces no `done_o`. A count of exactly 72 is valid and gives reload 0.
- R6: After `done_o`, `tick_o` is a one-cycle pulse that repeats every 2 × (reload + 1) clocks. This gives a bit rate of f_clk / (32 × (reload + 1)).
- R7: Asserting `arm_i` clears `err_o` and stops the baud generator. `tick_o` then stays 0 until the next `done_o`.
- R8: Line transitions after a completed or failed measurement, with no new `arm_i`, are ignored: there is no `done_o`, `reload_o` is unchanged and a running tick keeps its period.
- R9: With a 50 MHz clock and the default parameters, the learned rate is within 2.5% of the host rate for 9600, 19200, 38400, 57600 and 76800 baud. At 115200 the deviation is above 2.5%, while at 312500 the rate is exact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | One-cycle strobe that starts a new calibration |
| rx_i | input | 1 | Asynchronous serial receive line, high when idle |
| reload_o | output | CNT_W | Computed reload value |
| done_o | output | 1 | One-cycle pulse when a new reload value is valid |
| err_o | output | 1 | Measurement failed (overflow or span too short) |
| tick_o | output | 1 | 16x oversampling tick from the baud generator |

## Verification
The bench drives calibration bytes at seven standard rates, from 9600 to 312500 baud. Each case compares the reload value with one computed from the number of low clocks, and compares the tick spacing with the learned divisor. Together these cases separate a correct rounding offset from an off-by-one in the divide loop. The accuracy limit is also checked: it must pass at every rate up to 76800, fail at 115200 and pass again at 312500.

The boundary cases have their own patterns:
- spans of 287 and 288 clocks, which sit on either side of the minimum valid count;
- spans of 1019 and 1020 clocks on a narrow-counter instance, which sit on either side of overflow;
- a line held low while arming, which shows whether timing starts at the arm strobe or at a true falling edge;
- a second low pulse without re-arming, which must leave both the reload value and the tick unchanged.

// File: rtl/abd_pkg.sv
`timescale 1ns/1ps
package abd_pkg;
    typedef enum logic [1:0] {
        TM_IDLE = 2'd0,
        TM_WAIT = 2'd1,
        TM_MEAS = 2'd2
    } tm_state_e;
endpackage

// File: rtl/abd_sync.sv
`timescale 1ns/1ps
module abd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;
        else         sr_q <= sr_d;
    end

    assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/abd_span_timer.sv
`timescale 1ns/1ps
module abd_span_timer
    import abd_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 4,
    parameter int MIN_CNT  = 72
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic             rx_s_i,
    output logic             valid_o,
    output logic             err_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam int DIV_W = $clog2(TICK_DIV);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        tm_state_e        st;
        logic             prev;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] cnt;
        logic             valid;
        logic             err;
    } tm_t;

    tm_t d, q;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        d.prev  = rx_s_i;
        if (arm_i) begin
            d.st  = TM_WAIT;
            d.err = 1'b0;
        end else begin
            case (q.st)
                TM_WAIT: begin
                    if (q.prev && !rx_s_i) begin
                        d.st  = TM_MEAS;
                        d.div = DIV_W'(1);
                        d.cnt = '0;
                    end
                end
                TM_MEAS: begin
                    if (rx_s_i) begin
                        d.st = TM_IDLE;
                        if (q.cnt < CNT_W'(MIN_CNT)) d.err   = 1'b1;
                        else                         d.valid = 1'b1;
                    end else if (q.div == DIV_W'(TICK_DIV - 1)) begin
                        d.div = '0;
                        d.cnt = q.cnt + CNT_W'(1);
                        if (q.cnt == CNT_TOP - CNT_W'(1)) begin
                            d.err = 1'b1;
                            d.st  = TM_IDLE;
                        end
                    end else begin
                        d.div = q.div + DIV_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{st: TM_IDLE, prev: 1'b1, default: '0};
        else         q <= d;
    end

    assign valid_o = q.valid;
    assign err_o   = q.err;
    assign cnt_o   = q.cnt;

    // R7: an arm strobe always leaves the error flag clear
    assert_arm_clears_err_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        arm_i |=> !err_o);
    // R4/R5: a failed measurement never also reports a valid count
    assert_err_excludes_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_o) |-> !valid_o);
endmodule

// File: rtl/abd_reload_div.sv
`timescale 1ns/1ps
module abd_reload_div #(
    parameter int CNT_W = 16,
    parameter int UNIT  = 72,
    parameter int HALF  = 36
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             done_o,
    output logic [CNT_W-1:0] reload_o
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] rem;
        logic [CNT_W-1:0] quo;
        logic [CNT_W-1:0] rld;
        logic             done;
    } dv_t;

    dv_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start_i) begin
            d.busy = 1'b1;
            d.rem  = count_i - CNT_W'(HALF);
            d.quo  = '0;
        end else if (q.busy) begin
            if (q.rem >= CNT_W'(UNIT)) begin
                d.rem = q.rem - CNT_W'(UNIT);
                d.quo = q.quo + CNT_W'(1);
            end else begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.rld  = q.quo;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign done_o   = q.done;
    assign reload_o = q.rld;

    // checker state: count captured at start of each division
    logic [CNT_W-1:0] held_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      held_q <= '0;
        else if (start_i) held_q <= count_i;
    end

    // R3: reload is the rounded quotient of the captured count
    assert_quotient_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> ((int'(reload_o) * UNIT + HALF <= int'(held_q)) &&
                    (int'(held_q) < (int'(reload_o) + 1) * UNIT + HALF)));
    // R3: done is a single-cycle pulse
    assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
    // R5: the timer never hands over a count below the minimum
    assert_start_min_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> (count_i >= CNT_W'(UNIT)));
endmodule

// File: rtl/abd_tick_gen.sv
`timescale 1ns/1ps
module abd_tick_gen #(
    parameter int CNT_W   = 16,
    parameter int OVS_DIV = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic             stop_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             tick_o
);
    localparam int PW = CNT_W + 2;

    typedef struct packed {
        logic          en;
        logic [PW-1:0] per;
        logic [PW-1:0] pre;
        logic          tick;
    } tg_t;

    tg_t d, q;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (stop_i) begin
            d.en = 1'b0;
        end else if (load_i) begin
            d.en  = 1'b1;
            d.per = PW'(OVS_DIV) * (PW'(reload_i) + PW'(1));
            d.pre = d.per - PW'(1);
        end else if (q.en) begin
            if (q.pre == '0) begin
                d.tick = 1'b1;
                d.pre  = q.per - PW'(1);
            end else begin
                d.pre = q.pre - PW'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign tick_o = q.tick;

    // R6: every tick is one clock wide
    assert_tick_width_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    // R7: re-arming silences the tick on the next cycle
    assert_stop_silences_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_i |=> !tick_o);
endmodule

// File: rtl/autobaud_detect.sv
`timescale 1ns/1ps
module autobaud_detect #(
    parameter int CNT_W         = 16,
    parameter int TICK_DIV      = 4,
    parameter int SYNC_STAGES   = 2,
    parameter int FRAME_BITS    = 9,
    parameter int UNITS_PER_BIT = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             arm_i,
    input  logic             rx_i,
    output logic [CNT_W-1:0] reload_o,
    output logic             done_o,
    output logic             err_o,
    output logic             tick_o
);
    localparam int UNIT    = FRAME_BITS * UNITS_PER_BIT;
    localparam int HALF    = UNIT / 2;
    localparam int OVS_DIV = TICK_DIV * UNITS_PER_BIT / 16;

    logic             rx_s;
    logic             cnt_valid;
    logic [CNT_W-1:0] cnt;

    abd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    abd_span_timer #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV), .MIN_CNT(UNIT)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .arm_i  (arm_i),
        .rx_s_i (rx_s),
        .valid_o(cnt_valid),
        .err_o  (err_o),
        .cnt_o  (cnt)
    );

    abd_reload_div #(.CNT_W(CNT_W), .UNIT(UNIT), .HALF(HALF)) u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (cnt_valid),
        .count_i (cnt),
        .done_o  (done_o),
        .reload_o(reload_o)
    );

    abd_tick_gen #(.CNT_W(CNT_W), .OVS_DIV(OVS_DIV)) u_tick (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (done_o),
        .stop_i  (arm_i),
        .reload_i(reload_o),
        .tick_o  (tick_o)
    );
endmodule

// File: tb/autobaud_detect_tb_top.sv
`timescale 1ns/1ps
module autobaud_detect_tb_top;
    localparam longint FCLK = 50_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0, rx = 1'b1;
    logic arm2 = 1'b0, rx2 = 1'b1;
    logic [15:0] reload;
    logic done, err, tick;
    logic [7:0] reload2;
    logic done2, err2, tick2;

    always #10 clk = ~clk;

    autobaud_detect dut_i (
        .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .rx_i(rx),
        .reload_o(reload), .done_o(done), .err_o(err), .tick_o(tick)
    );

    autobaud_detect #(.CNT_W(8)) ovf_i (
        .clk_i(clk), .rst_ni(rst_n), .arm_i(arm2), .rx_i(rx2),
        .reload_o(reload2), .done_o(done2), .err_o(err2), .tick_o(tick2)
    );

    int n_chk = 0, n_fail = 0;
    longint cyc = 0;
    int done_seen = 0, done2_seen = 0;
    bit gen_off = 1'b1;
    longint exp_per = 0, last_tick = -1;
    int exp_rld = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: expected tick spacing and silence, every clock
    always @(negedge clk) begin
        cyc++;
        if (done)  begin done_seen++;  gen_off = 1'b0; exp_per = 2 * (exp_rld + 1); last_tick = -1; end
        if (done2) done2_seen++;
        if (tick) begin
            if (gen_off) check(1'b0, "R7", "tick while generator idle", 1, 0);
            else if (last_tick >= 0 && exp_per > 0)
                check(cyc - last_tick == exp_per, "R6", "tick spacing", cyc - last_tick, exp_per);
            last_tick = cyc;
        end
    end

    task automatic arm_dut();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
        gen_off = 1'b1; exp_per = 0; last_tick = -1;
    endtask

    task automatic low_span(input int len);
        @(negedge clk) rx = 1'b0;
        repeat (len) @(negedge clk);
        rx = 1'b1;
    endtask

    function automatic int model_reload(input int len);
        return ((len / 4) - 36) / 72;
    endfunction

    task automatic run_rate(input int baud, input bit exp_pass);
        int len;
        real act, dev;
        len = int'((9 * FCLK + baud / 2) / baud);
        arm_dut();
        repeat (10) @(negedge clk);
        exp_rld = model_reload(len);
        done_seen = 0;
        low_span(len);
        repeat (1500) @(negedge clk);
        check(done_seen == 1, "R3", "done pulses", done_seen, 1);
        check(reload == 16'(exp_rld), "R2", "reload from span", reload, exp_rld);
        check(err == 1'b0, "R3", "no error", err, 0);
        act = real'(FCLK) / (32.0 * real'(reload + 1));
        dev = (act > baud ? act - baud : baud - act) * 100.0 / real'(baud);
        check((dev <= 2.5) == exp_pass, "R9", $sformatf("deviation at %0d baud", baud),
              longint'(dev * 100.0), exp_pass ? 250 : 251);
        repeat (4 * (2 * (exp_rld + 1)) + 4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(reload == 0, "R1", "reload after reset", reload, 0);
        check(done == 0,   "R1", "done after reset", done, 0);
        check(err == 0,    "R1", "err after reset", err, 0);
        check(tick == 0,   "R1", "tick after reset", tick, 0);

        run_rate(9600,   1'b1);
        run_rate(19200,  1'b1);
        run_rate(38400,  1'b1);
        run_rate(57600,  1'b1);
        run_rate(76800,  1'b1);
        run_rate(115200, 1'b0);
        run_rate(312500, 1'b1);

        // R8: another low pulse with no re-arm is ignored
        done_seen = 0;
        low_span(3000);
        repeat (200) @(negedge clk);
        check(done_seen == 0, "R8", "done without re-arm", done_seen, 0);
        check(reload == 4, "R8", "reload kept", reload, 4);

        // R5: too-short span
        arm_dut();
        repeat (10) @(negedge clk);
        done_seen = 0;
        low_span(287);
        repeat (600) @(negedge clk);
        check(err == 1, "R5", "error for count 71", err, 1);
        check(done_seen == 0, "R5", "no done for count 71", done_seen, 0);

        // R7: arm clears the error
        arm_dut();
        check(err == 0, "R7", "error cleared by arm", err, 0);

        // R5 boundary at count 72, R2 line already low at arm
        rx = 1'b0;
        repeat (50) @(negedge clk);
        arm_dut();
        repeat (300) @(negedge clk);
        rx = 1'b1;
        repeat (20) @(negedge clk);
        check(done_seen == 0, "R2", "no timing from arm while low", done_seen, 0);
        exp_rld = 0;
        low_span(288);
        repeat (100) @(negedge clk);
        check(done_seen == 1, "R5", "done for count 72", done_seen, 1);
        check(reload == 0, "R5", "reload for count 72", reload, 0);
        check(err == 0, "R5", "no error for count 72", err, 0);
        repeat (20) @(negedge clk);

        // R4 on narrow counter: 1019 clocks valid, 1020 overflows
        @(negedge clk) arm2 = 1'b1;
        @(negedge clk) arm2 = 1'b0;
        repeat (5) @(negedge clk);
        done2_seen = 0;
        @(negedge clk) rx2 = 1'b0;
        repeat (1019) @(negedge clk);
        rx2 = 1'b1;
        repeat (100) @(negedge clk);
        check(done2_seen == 1, "R4", "done below overflow", done2_seen, 1);
        check(reload2 == 8'd3, "R4", "reload below overflow", reload2, 3);
        check(err2 == 0, "R4", "no error below overflow", err2, 0);
        @(negedge clk) arm2 = 1'b1;
        @(negedge clk) arm2 = 1'b0;
        repeat (5) @(negedge clk);
        done2_seen = 0;
        @(negedge clk) rx2 = 1'b0;
        repeat (1030) @(negedge clk);
        check(err2 == 1, "R4", "error while still low", err2, 1);
        rx2 = 1'b1;
        repeat (100) @(negedge clk);
        check(done2_seen == 0, "R4", "no done after overflow", done2_seen, 0);
        check(reload2 == 8'd3, "R4", "reload kept after overflow", reload2, 3);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R1", "watchdog expired", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule